// File: doc/BRIEF.md
# Transmit FCS and Source Address Inserter

This block sits in the transmit path of a 10 Gb/s Ethernet MAC, between the client stream and the framing logic. Client frames arrive eight bytes per beat on a valid/ready stream with start, end and empty markers. They carry no frame check sequence. The block can overwrite the source address field with a configured station address. It then computes the IEEE 802.3 CRC-32 over the frame as it leaves and appends the result as a four-byte FCS. The output is a stream of the same kind.

The CRC covers every byte the client supplies (destination, source, length/type, payload, pad), after any address rewrite. When the last input beat has more than four valid bytes, the FCS does not fit in that beat. Part of it then goes into one extra output beat, and the input is held off for that cycle. Both features are switched by configuration inputs. These are captured on the first beat of each frame and hold for the rest of it.

Top module: `txfcs_inserter`

## Requirements
- R1: The FCS is the CRC-32 with generator polynomial 0x04C11DB7, register preset to all ones, each byte fed least significant bit first, and the final register inverted. Bit 0 of the inverted register (the x^31 term) is the least significant bit of the first FCS byte, and the four bytes follow in rising significance. For the nine ASCII bytes "123456789" the appended bytes are 0x26, 0x39, 0xF4, 0xCB.
- R2: Byte lane k of a beat occupies data bits [8k+7:8k], and lane 0 is the earliest byte. On an end-of-packet beat, `empty` gives the number of unused lanes at the top. The start marker appears on the first output beat of every frame and on no other beat.
- R3: When insertion is on and the last input beat has at most four valid bytes, the FCS occupies the lanes right after the last valid byte in that same beat, and the output `empty` equals the input `empty` minus 4.
- R4: When insertion is on and the last input beat has n > 4 valid bytes, that beat leaves without end marker and carries the first 8-n FCS bytes. One further beat follows, carrying the remaining n-4 FCS bytes in its lowest lanes, with the end marker set and `empty` equal to 12-n.
- R5: While the extra FCS beat of R4 is waiting, `in_ready` is low, so no input beat is lost or reordered.
- R6: When address replacement is on, frame bytes 6 to 11 become `cfg_station_addr` bytes 0 to 5, where frame byte 6+i is taken from bits [8i+7:8i]. The FCS is computed over the replaced bytes.
- R7: When insertion is off, the frame leaves with its bytes (after any replacement), length, end marker and `empty` unchanged, and no FCS is added.
- R8: The two enables and the station address are taken on the start-of-packet beat and used for the whole frame. Changes made later in the frame do not affect it.
- R9: While `out_valid` is high and `out_ready` is low, the output beat stays valid and unchanged.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_addr_replace | input | 1 | Enables source address replacement |
| cfg_station_addr | input | 48 | Station address, frame byte 6+i in bits [8i+7:8i] |
| cfg_crc_insert | input | 1 | Enables FCS computation and append |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | 64 | Input data, lane 0 first |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused top lanes on the last beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 64 | Output data, lane 0 first |
| out_sop | output | 1 | First beat of an output frame |
| out_eop | output | 1 | Last beat of an output frame |
| out_empty | output | 3 | Unused top lanes on the output last beat |

## Verification
Frames with every length from 60 to 75 bytes place the last valid byte in every lane. This separates the same-beat FCS case from the extra-beat case and checks each `empty` value on both paths. Alternating address replacement across that sweep, together with short frames that end inside the address field, shows whether the CRC covers the rewritten bytes or the client's. Frames with insertion off, and frames whose enables and address change after the first beat, separate sampling at frame start from live use. Random downstream stalls, checked against a byte-queue model, show whether the extra beat swallows or repeats input data.

// File: rtl/txfcs_pkg.sv
// Package: constants shared by the transmit FCS inserter.
// Assumes the reflected (LSB-first) CRC-32 form used on Ethernet.
package txfcs_pkg;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam int          FCS_BYTES     = 4;
    localparam int          SA_FIRST      = 6;
    localparam int          SA_LAST       = 11;
endpackage

// File: rtl/txfcs_crc_step.sv
// Module: combinational CRC-32 update over the first nbytes lanes of one beat.
// Assumes lane 0 is the earliest byte and each byte enters LSB first.
module txfcs_crc_step #(
    parameter int BYTES = 8,
    localparam int DATA_W = 8 * BYTES,
    localparam int CNT_W  = $clog2(BYTES + 1)
) (
    input  logic [31:0]       crc_in,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  nbytes,
    output logic [31:0]       crc_out
);
    import txfcs_pkg::*;

    logic [31:0] c;

    // Purpose: fold every valid byte of the beat into the running CRC.
    always_comb begin
        c = crc_in;
        for (int k = 0; k < BYTES; k++) begin
            if (k < int'(nbytes)) begin
                for (int b = 0; b < 8; b++) begin
                    if (c[0] ^ data[8*k+b])
                        c = (c >> 1) ^ CRC_POLY_REFL;
                    else
                        c = c >> 1;
                end
            end
        end
        crc_out = c;
    end
endmodule

// File: rtl/txfcs_sa_patch.sv
// Module: replaces frame bytes 6..11 with the station address when enabled.
// Assumes beat_idx saturates at or beyond the last beat touching the field.
module txfcs_sa_patch #(
    parameter int BYTES = 8,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        beat_idx,
    input  logic              enable,
    input  logic [47:0]       station,
    output logic [DATA_W-1:0] data_out
);
    import txfcs_pkg::*;

    // Purpose: overwrite each lane whose frame position falls in the address field.
    always_comb begin
        data_out = data_in;
        for (int k = 0; k < BYTES; k++) begin
            if (enable && (int'(beat_idx) * BYTES + k >= SA_FIRST)
                       && (int'(beat_idx) * BYTES + k <= SA_LAST))
                data_out[8*k +: 8] = station[8*(int'(beat_idx) * BYTES + k - SA_FIRST) +: 8];
        end
    end
endmodule

// File: rtl/txfcs_lane_merge.sv
// Module: places the four FCS bytes after the last valid byte of the final beat,
// producing the main beat and the overflow beat contents.
// Assumes BYTES >= 4; spill_out is meaningful only when nvalid > 4.
module txfcs_lane_merge #(
    parameter int BYTES = 8,
    localparam int DATA_W = 8 * BYTES,
    localparam int CNT_W  = $clog2(BYTES + 1)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  nvalid,
    input  logic [31:0]       fcs,
    output logic [DATA_W-1:0] main_out,
    output logic [DATA_W-1:0] spill_out
);
    import txfcs_pkg::*;

    // Purpose: drop FCS bytes into free lanes and carry the rest into the spill beat.
    always_comb begin
        main_out  = data_in;
        spill_out = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (k >= int'(nvalid) && k < int'(nvalid) + FCS_BYTES)
                main_out[8*k +: 8] = fcs[8*(k - int'(nvalid)) +: 8];
        end
        for (int j = 0; j < BYTES; j++) begin
            if (BYTES - int'(nvalid) + j >= 0 && BYTES - int'(nvalid) + j < FCS_BYTES)
                spill_out[8*j +: 8] = fcs[8*(BYTES - int'(nvalid) + j) +: 8];
        end
    end
endmodule

// File: rtl/txfcs_inserter.sv
// Module: transmit-side source address rewrite and CRC-32 FCS append on a
// BYTES-wide valid/ready stream with sop/eop/empty markers.
// Assumes: BYTES >= 4, frames of at least one byte, empty only meaningful on eop.
// Configuration is captured on the sop beat and held for the frame.
module txfcs_inserter #(
    parameter int BYTES = 8,
    localparam int DATA_W   = 8 * BYTES,
    localparam int EMPTY_W  = $clog2(BYTES),
    localparam int CNT_W    = $clog2(BYTES + 1),
    localparam int SA_BEATS = (txfcs_pkg::SA_LAST + BYTES) / BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_addr_replace,
    input  logic [47:0]        cfg_station_addr,
    input  logic               cfg_crc_insert,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty
);
    import txfcs_pkg::*;

    // Frame state
    logic [31:0]        crc_q;
    logic               repl_q, ins_q;
    logic [47:0]        addr_q;
    logic [1:0]         beat_q;
    // Overflow beat
    logic               pend_q;
    logic [DATA_W-1:0]  spill_q;
    logic [EMPTY_W-1:0] spill_empty_q;

    // Effective per-beat values
    logic               acc;
    logic [1:0]         beat_idx;
    logic               repl_eff, ins_eff;
    logic [47:0]        addr_eff;
    logic [31:0]        crc_seed, crc_nx;
    logic [CNT_W-1:0]   nvalid;
    logic               spill_need;
    logic [DATA_W-1:0]  patched, merged, spill_data;
    logic [EMPTY_W-1:0] tail_empty, spill_empty;

    assign in_ready = !pend_q && (!out_valid || out_ready);
    assign acc      = in_valid && in_ready;

    // Purpose: choose sop-time configuration or the values held for the frame.
    always_comb begin
        beat_idx    = in_sop ? 2'd0 : beat_q;
        repl_eff    = in_sop ? cfg_addr_replace : repl_q;
        ins_eff     = in_sop ? cfg_crc_insert : ins_q;
        addr_eff    = in_sop ? cfg_station_addr : addr_q;
        crc_seed    = in_sop ? CRC_PRESET : crc_q;
        nvalid      = in_eop ? CNT_W'(BYTES) - CNT_W'(in_empty) : CNT_W'(BYTES);
        spill_need  = ins_eff && in_eop && (int'(nvalid) > FCS_BYTES);
        tail_empty  = EMPTY_W'(BYTES - FCS_BYTES - int'(nvalid));
        spill_empty = EMPTY_W'(BYTES + FCS_BYTES - int'(nvalid));
    end

    txfcs_sa_patch #(.BYTES(BYTES)) u_patch (
        .data_in  (in_data),
        .beat_idx (beat_idx),
        .enable   (repl_eff),
        .station  (addr_eff),
        .data_out (patched)
    );

    txfcs_crc_step #(.BYTES(BYTES)) u_crc (
        .crc_in  (crc_seed),
        .data    (patched),
        .nbytes  (nvalid),
        .crc_out (crc_nx)
    );

    txfcs_lane_merge #(.BYTES(BYTES)) u_merge (
        .data_in   (patched),
        .nvalid    (nvalid),
        .fcs       (~crc_nx),
        .main_out  (merged),
        .spill_out (spill_data)
    );

    // Purpose: track CRC, beat position and the frame's captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= CRC_PRESET;
            repl_q <= 1'b0;
            ins_q  <= 1'b0;
            addr_q <= '0;
            beat_q <= 2'd0;
        end else if (acc) begin
            crc_q  <= crc_nx;
            repl_q <= repl_eff;
            ins_q  <= ins_eff;
            addr_q <= addr_eff;
            beat_q <= (int'(beat_idx) >= SA_BEATS) ? beat_idx : beat_idx + 2'd1;
        end
    end

    // Purpose: output register stage, issuing the pending overflow beat first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_sop       <= 1'b0;
            out_eop       <= 1'b0;
            out_empty     <= '0;
            pend_q        <= 1'b0;
            spill_q       <= '0;
            spill_empty_q <= '0;
        end else if (pend_q && (!out_valid || out_ready)) begin
            out_valid <= 1'b1;
            out_data  <= spill_q;
            out_sop   <= 1'b0;
            out_eop   <= 1'b1;
            out_empty <= spill_empty_q;
            pend_q    <= 1'b0;
        end else if (acc) begin
            out_valid <= 1'b1;
            out_data  <= (ins_eff && in_eop) ? merged : patched;
            out_sop   <= in_sop;
            out_eop   <= in_eop && !spill_need;
            out_empty <= (ins_eff && in_eop && !spill_need) ? tail_empty : in_empty;
            if (spill_need) begin
                pend_q        <= 1'b1;
                spill_q       <= spill_data;
                spill_empty_q <= spill_empty;
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/txfcs_checker.sv
// Module: protocol properties of the FCS inserter, attached by bind.
// Assumes it observes the top's ports plus its overflow-pending flag.
module txfcs_checker #(
    parameter int BYTES = 8,
    localparam int DATA_W = 8 * BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              pend_q
);
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop)); // R9

    AST_SPILL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !in_ready); // R5

    AST_SPILL_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && out_ready |=> out_valid && out_eop && !out_sop); // R4

    AST_SOP_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_sop |=> out_valid && out_sop); // R2
endmodule

bind txfcs_inserter txfcs_checker #(.BYTES(BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .pend_q    (pend_q)
);

// File: tb/tb_txfcs_inserter.sv
// Bench: byte-queue reference model compared against every accepted output beat.
module tb_txfcs_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_addr_replace = 1'b0;
    logic [47:0] cfg_station_addr = 48'h0;
    logic        cfg_crc_insert = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [2:0]  in_empty = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic [2:0]  out_empty;

    int checks = 0;
    int errors = 0;
    bit backpressure = 1'b0;
    string cur_req = "R3";

    logic [7:0] exp_q[$];
    int         exp_len_q[$];
    logic [7:0] rx_frame[$];
    logic [7:0] last_frame[$];
    int         rx_cnt = 0;
    bit         hold_prev = 1'b0;
    logic [63:0] prev_data = '0;

    txfcs_inserter dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_replace(cfg_addr_replace), .cfg_station_addr(cfg_station_addr),
        .cfg_crc_insert(cfg_crc_insert),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ref_fcs(input logic [7:0] d[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (d[i]) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ d[i][b]) c = (c >> 1) ^ 32'hEDB88320;
                else c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Downstream ready pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = backpressure ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // Output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev)
                check(out_valid && out_data == prev_data, "R9", "stalled beat changed",
                      longint'(out_data), longint'(prev_data));
            if (out_valid && out_ready) begin
                int n;
                bit ok;
                logic [7:0] got, want;
                n = out_eop ? 8 - int'(out_empty) : 8;
                check(out_sop == (rx_cnt == 0), "R2", "sop marker", out_sop, rx_cnt == 0);
                ok = 1'b1;
                got = 8'h0;
                want = 8'h0;
                for (int l = 0; l < n; l++) begin
                    logic [7:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
                    if (out_data[8*l +: 8] !== e && ok) begin
                        ok = 1'b0;
                        got = out_data[8*l +: 8];
                        want = e;
                    end
                    rx_frame.push_back(out_data[8*l +: 8]);
                end
                check(ok, cur_req, "beat byte", got, want);
                rx_cnt += n;
                if (out_eop) begin
                    int el;
                    el = (exp_len_q.size() > 0) ? exp_len_q.pop_front() : -1;
                    check(rx_cnt == el, cur_req, "frame length", rx_cnt, el);
                    last_frame = rx_frame;
                    rx_frame.delete();
                    rx_cnt = 0;
                end
            end
            hold_prev = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    task automatic send_frame(input logic [7:0] fr[$], input bit repl, input bit ins,
                              input bit flip);
        logic [7:0] e[$];
        int nbeats, last_n;
        e = fr;
        if (repl)
            for (int i = 6; i <= 11; i++)
                if (i < e.size()) e[i] = cfg_station_addr[8*(i-6) +: 8];
        if (ins) begin
            logic [31:0] c;
            c = ref_fcs(e);
            for (int k = 0; k < 4; k++) e.push_back(c[8*k +: 8]);
        end
        foreach (e[i]) exp_q.push_back(e[i]);
        exp_len_q.push_back(e.size());
        cfg_addr_replace = repl;
        cfg_crc_insert = ins;
        nbeats = (fr.size() + 7) / 8;
        last_n = fr.size() - (nbeats - 1) * 8;
        for (int b = 0; b < nbeats; b++) begin
            for (int l = 0; l < 8; l++)
                in_data[8*l +: 8] = (b*8 + l < fr.size()) ? fr[b*8 + l] : 8'hEE;
            in_valid = 1'b1;
            in_sop = (b == 0);
            in_eop = (b == nbeats - 1);
            in_empty = (b == nbeats - 1) ? 3'(8 - last_n) : 3'd0;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
            if (flip && b == 0) begin
                cfg_addr_replace = ~repl;
                cfg_crc_insert = ~ins;
                cfg_station_addr = ~cfg_station_addr;
            end
        end
        in_valid = 1'b0;
        in_sop = 1'b0;
        in_eop = 1'b0;
        if (ins && last_n > 4) begin
            @(negedge clk);
            check(!in_ready, "R5", "in_ready during overflow beat", in_ready, 0);
        end
    endtask

    task automatic wait_idle();
        while (exp_len_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic make_frame(output logic [7:0] fr[$], input int len, input int seed);
        fr.delete();
        for (int i = 0; i < len; i++) fr.push_back(8'((i * 7 + seed * 13 + 1) & 8'hFF));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] fr[$];
        cfg_station_addr = 48'hA5B4C3D2E1F0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
        @(posedge clk);
        #1;

        // Known check string
        cur_req = "R1";
        fr.delete();
        for (int i = 0; i < 9; i++) fr.push_back(8'h31 + 8'(i));
        send_frame(fr, 1'b0, 1'b1, 1'b0);
        wait_idle();
        check(last_frame.size() == 13, "R1", "check string length", last_frame.size(), 13);
        if (last_frame.size() == 13)
            check({last_frame[12], last_frame[11], last_frame[10], last_frame[9]} == 32'hCBF43926,
                  "R1", "check string FCS",
                  {last_frame[12], last_frame[11], last_frame[10], last_frame[9]}, 32'hCBF43926);

        // Length sweep: every end lane, alternating replacement
        for (int len = 60; len <= 75; len++) begin
            cur_req = ((len % 8) >= 1 && (len % 8) <= 4) ? "R3" : "R4";
            if (len % 2 == 1) cur_req = "R6";
            make_frame(fr, len, len);
            send_frame(fr, len % 2 == 1, 1'b1, 1'b0);
        end
        wait_idle();

        // Frames ending inside the address field
        cur_req = "R6";
        for (int len = 7; len <= 12; len++) begin
            make_frame(fr, len, len + 3);
            send_frame(fr, 1'b1, 1'b1, 1'b0);
        end
        wait_idle();

        // Insertion off
        cur_req = "R7";
        for (int len = 61; len <= 68; len++) begin
            make_frame(fr, len, len + 5);
            send_frame(fr, len % 2 == 0, 1'b0, 1'b0);
        end
        wait_idle();

        // Mid-frame configuration changes
        cur_req = "R8";
        make_frame(fr, 45, 2);
        send_frame(fr, 1'b1, 1'b1, 1'b1);
        make_frame(fr, 46, 3);
        send_frame(fr, 1'b0, 1'b0, 1'b1);
        make_frame(fr, 30, 4);
        send_frame(fr, 1'b1, 1'b0, 1'b1);
        wait_idle();

        // Random downstream stalls
        cur_req = "R9";
        backpressure = 1'b1;
        for (int len = 60; len <= 71; len++) begin
            make_frame(fr, len, len + 9);
            send_frame(fr, len % 3 == 0, len % 4 != 0, 1'b0);
        end
        wait_idle();
        backpressure = 1'b0;
        repeat (5) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule